// File: doc/BRIEF.md
# Peripheral-to-Memory Byte DMA Channel

This block is one DMA channel that drains a peripheral receive data register into a memory buffer. A level request from the peripheral, typically a serial receiver with a byte waiting, starts one minor loop. Each minor loop moves a programmed number of bytes. For each byte the channel performs one read cycle on the peripheral port, then one write cycle on the memory port. The source and destination addresses step by signed offsets after every byte.

A descriptor holds the following values: the source and destination addresses and their offsets, the byte count per request, the starting iteration count, a signed end-of-buffer destination adjustment, and three option flags. A current iteration counter counts minor loops down to the end of a major loop. At that point the counter reloads and the destination pointer is adjusted, which makes a circular buffer possible. The channel can also drop its own request enable at that point, so that it fills exactly one buffer.

Sticky interrupt bits report the half-way point and completion. Software clears them by writing ones.

Top module: `dma_rx_channel`

## Requirements
- R1: Each accepted request runs one minor loop of `cfg_nbytes` bytes (a count of 0 is taken as 1). Each byte is one cycle with `prd_en` high at `prd_addr`, followed by one cycle with `mwr_en` high that writes the byte sampled during that read.
- R2: The source address advances by the sign-extended `cfg_src_off` after every byte. An offset of 0 keeps every read on the same peripheral address.
- R3: The destination address advances by the sign-extended `cfg_dst_off` after every byte, and negative offsets walk downward.
- R4: A descriptor load sets the current count (`citer_out`) to `cfg_biter`. Each minor loop lowers it by one. The minor loop that starts at a count of 1 completes the major loop and reloads the count with the beginning value.
- R5: On major-loop completion, the signed `cfg_dst_last` is added to the destination address on top of the last byte's offset step. Setting it to minus the buffer length returns the pointer to the buffer start.
- R6: If flag bit 2 (auto-stop) is set, the request enable (`req_enabled`) falls at major-loop completion, and later requests move nothing.
- R7: If flag bit 0 is set, `irq_done` sets at major-loop completion. If flag bit 1 is set, `irq_half` sets when a minor loop leaves the count equal to `cfg_biter`/2 (rounded down, nonzero). Both bits stay set until `irq_clr` is written with a one in bit 0 (done) or bit 1 (half).
- R8: While no request is serviced, no port cycles occur and the current count holds its value.
- R9: A request level that stays high after its minor loop is not serviced again until it has been seen low.
- R10: Pulsing `erq_clr` in the middle of a minor loop lets that loop finish, with `req_enabled` still high, and drops the enable at its end. Requests that arrive while the enable is low are ignored.
- R11: A descriptor load offered while a minor loop is in progress is ignored. Addresses and count continue from their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load the descriptor fields below (ignored while busy) |
| cfg_src_addr | input | AW | Peripheral source address |
| cfg_src_off | input | OW | Signed source step per byte |
| cfg_dst_addr | input | AW | Buffer destination address |
| cfg_dst_off | input | OW | Signed destination step per byte |
| cfg_dst_last | input | AW | Signed destination adjustment at major completion |
| cfg_biter | input | CW | Beginning iteration count (minor loops per major loop) |
| cfg_nbytes | input | NBW | Bytes per minor loop |
| cfg_flags | input | 3 | bit0 done irq enable, bit1 half irq enable, bit2 auto-stop |
| erq_set | input | 1 | Set the request enable |
| erq_clr | input | 1 | Clear the request enable (deferred to loop end when busy) |
| irq_clr | input | 2 | Write-one-to-clear: bit0 done, bit1 half |
| periph_req | input | 1 | Peripheral request level |
| prd_en | output | 1 | Peripheral read strobe |
| prd_addr | output | AW | Peripheral read address |
| prd_data | input | 8 | Peripheral read data, valid in the strobe cycle |
| mwr_en | output | 1 | Memory write strobe |
| mwr_addr | output | AW | Memory write address |
| mwr_data | output | 8 | Memory write data |
| req_enabled | output | 1 | Request enable state |
| busy | output | 1 | Minor loop in progress |
| citer_out | output | CW | Current iteration count |
| dst_addr_out | output | AW | Current destination address |
| irq_done | output | 1 | Sticky major-completion interrupt |
| irq_half | output | 1 | Sticky half-way interrupt |

## Verification
The assertions assume the following about the inputs:
- Once the peripheral raises its request, it holds the request high until its minor loop ends, so any high level seen at loop end is the serviced request and not a fresh one.
- Every loaded beginning count is at least one.

The stimulus follows both rules:
- It raises the request only while the channel is idle.
- It releases the request only after `busy` has fallen.
- It loads only nonzero counts.
- Its sole mid-loop actions are the enable-clear pulse and the rejected load.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  typedef enum logic [1:0] {CH_IDLE, CH_READ, CH_WRITE} ch_state_e;
  localparam int FLG_DONE_IE  = 0;
  localparam int FLG_HALF_IE  = 1;
  localparam int FLG_AUTOSTOP = 2;
  localparam int FLG_W        = 3;
endpackage

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
  import dmach_pkg::*;
#(
  parameter int NBW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [NBW-1:0] cfg_nbytes,
  input  logic           cfg_autostop,
  input  logic           periph_req,
  input  logic           erq_set,
  input  logic           erq_clr,
  input  logic           major_hit,
  output logic           start_minor,
  output logic           rd_phase,
  output logic           wr_phase,
  output logic           minor_end,
  output logic           busy,
  output logic           erq
);
  ch_state_e      state;
  logic [NBW-1:0] nbytes_q;
  logic [NBW-1:0] bcnt;
  logic           autostop_q;
  logic           armed;
  logic           pend_clr;
  logic           erq_n, pend_n;

  function automatic logic last_byte(input logic [NBW-1:0] c);
    return c <= NBW'(1);
  endfunction

  assign busy        = (state != CH_IDLE);
  assign rd_phase    = (state == CH_READ);
  assign wr_phase    = (state == CH_WRITE);
  assign start_minor = (state == CH_IDLE) && erq && armed && periph_req;
  assign minor_end   = wr_phase && last_byte(bcnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CH_IDLE;
      bcnt  <= '0;
    end else begin
      case (state)
        CH_IDLE: if (start_minor) begin
          state <= CH_READ;
          bcnt  <= nbytes_q;
        end
        CH_READ: state <= CH_WRITE;
        CH_WRITE: begin
          if (last_byte(bcnt)) state <= CH_IDLE;
          else begin
            bcnt  <= bcnt - NBW'(1);
            state <= CH_READ;
          end
        end
        default: state <= CH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbytes_q   <= NBW'(1);
      autostop_q <= 1'b0;
    end else if (load) begin
      nbytes_q   <= cfg_nbytes;
      autostop_q <= cfg_autostop;
    end
  end

  // request edge qualification: re-armed only by a low level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           armed <= 1'b1;
    else if (start_minor) armed <= 1'b0;
    else if (!periph_req) armed <= 1'b1;
  end

  always_comb begin
    erq_n  = erq;
    pend_n = pend_clr;
    if (erq_clr) begin
      if (busy && !minor_end) pend_n = 1'b1;
      else                    erq_n  = 1'b0;
    end
    if (minor_end && (pend_clr || (major_hit && autostop_q))) begin
      erq_n  = 1'b0;
      pend_n = 1'b0;
    end
    if (erq_set) begin
      erq_n  = 1'b1;
      pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erq      <= 1'b0;
      pend_clr <= 1'b0;
    end else begin
      erq      <= erq_n;
      pend_clr <= pend_n;
    end
  end

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    minor_end && periph_req |=> !start_minor); // R9
  AST_AUTO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    minor_end && major_hit && autostop_q && !erq_set |=> !erq); // R6
  AST_CLR_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    erq && erq_clr && busy && !minor_end && !erq_set |=> erq); // R10
  AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !erq && !erq_set |=> !rd_phase || busy && $past(busy)); // R10
endmodule

// File: rtl/dmach_addr.sv
module dmach_addr #(
  parameter int AW = 16,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [OW-1:0] cfg_src_off,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [OW-1:0] cfg_dst_off,
  input  logic [AW-1:0] cfg_dst_last,
  input  logic          byte_wr,
  input  logic          major_hit,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr
);
  localparam int EXT = AW - OW;

  logic [OW-1:0] soff_q, doff_q;
  logic [AW-1:0] dlast_q;

  function automatic logic [AW-1:0] widen(input logic [OW-1:0] off);
    return {{EXT{off[OW-1]}}, off};
  endfunction

  function automatic logic [AW-1:0] step_dst(input logic [AW-1:0] a,
                                             input logic [OW-1:0] off,
                                             input logic [AW-1:0] last,
                                             input logic wrap);
    return a + widen(off) + (wrap ? last : '0);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr <= '0;
      dst_addr <= '0;
      soff_q   <= '0;
      doff_q   <= '0;
      dlast_q  <= '0;
    end else if (load) begin
      src_addr <= cfg_src_addr;
      dst_addr <= cfg_dst_addr;
      soff_q   <= cfg_src_off;
      doff_q   <= cfg_dst_off;
      dlast_q  <= cfg_dst_last;
    end else if (byte_wr) begin
      src_addr <= src_addr + widen(soff_q);
      dst_addr <= step_dst(dst_addr, doff_q, dlast_q, major_hit);
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_wr && !load |=> $stable(src_addr) && $stable(dst_addr)); // R8
endmodule

// File: rtl/dmach_iter.sv
module dmach_iter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] cfg_biter,
  input  logic          cfg_done_ie,
  input  logic          cfg_half_ie,
  input  logic          minor_end,
  input  logic [1:0]    irq_clr,
  output logic [CW-1:0] citer,
  output logic          major_hit,
  output logic          irq_done,
  output logic          irq_half
);
  logic [CW-1:0] biter;
  logic          done_ie_q, half_ie_q;
  logic          half_hit;

  function automatic logic is_last(input logic [CW-1:0] c);
    return c == CW'(1);
  endfunction

  function automatic logic [CW-1:0] half_mark(input logic [CW-1:0] b);
    return b >> 1;
  endfunction

  function automatic logic reaches_half(input logic [CW-1:0] c, input logic [CW-1:0] b);
    return !is_last(c) && (half_mark(b) != '0) && ((c - CW'(1)) == half_mark(b));
  endfunction

  assign major_hit = minor_end && is_last(citer);
  assign half_hit  = minor_end && reaches_half(citer, biter);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      biter     <= CW'(1);
      citer     <= CW'(1);
      done_ie_q <= 1'b0;
      half_ie_q <= 1'b0;
    end else if (load) begin
      biter     <= cfg_biter;
      citer     <= cfg_biter;
      done_ie_q <= cfg_done_ie;
      half_ie_q <= cfg_half_ie;
    end else if (minor_end) begin
      citer <= is_last(citer) ? biter : citer - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_done <= 1'b0;
      irq_half <= 1'b0;
    end else begin
      if (major_hit && done_ie_q)  irq_done <= 1'b1;
      else if (irq_clr[0])         irq_done <= 1'b0;
      if (half_hit && half_ie_q)   irq_half <= 1'b1;
      else if (irq_clr[1])         irq_half <= 1'b0;
    end
  end

  AST_CITER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    citer != '0 && citer <= biter); // R4
  AST_CITER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !minor_end && !load |=> $stable(citer)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done && !irq_clr[0] |=> irq_done); // R7
  AST_HALF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_half && !irq_clr[1] |=> irq_half); // R7
endmodule

// File: rtl/dma_rx_channel.sv
module dma_rx_channel
  import dmach_pkg::*;
#(
  parameter int AW  = 16,
  parameter int OW  = 8,
  parameter int CW  = 8,
  parameter int NBW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [AW-1:0]    cfg_src_addr,
  input  logic [OW-1:0]    cfg_src_off,
  input  logic [AW-1:0]    cfg_dst_addr,
  input  logic [OW-1:0]    cfg_dst_off,
  input  logic [AW-1:0]    cfg_dst_last,
  input  logic [CW-1:0]    cfg_biter,
  input  logic [NBW-1:0]   cfg_nbytes,
  input  logic [FLG_W-1:0] cfg_flags,
  input  logic             erq_set,
  input  logic             erq_clr,
  input  logic [1:0]       irq_clr,
  input  logic             periph_req,
  output logic             prd_en,
  output logic [AW-1:0]    prd_addr,
  input  logic [7:0]       prd_data,
  output logic             mwr_en,
  output logic [AW-1:0]    mwr_addr,
  output logic [7:0]       mwr_data,
  output logic             req_enabled,
  output logic             busy,
  output logic [CW-1:0]    citer_out,
  output logic [AW-1:0]    dst_addr_out,
  output logic             irq_done,
  output logic             irq_half
);
  logic          load_ok;
  logic          start_minor, rd_phase, wr_phase, minor_end, major_hit;
  logic [AW-1:0] src_addr, dst_addr;
  logic [7:0]    rdata;

  assign load_ok = cfg_load && !busy;

  dmach_ctrl #(.NBW(NBW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(load_ok),
    .cfg_nbytes(cfg_nbytes), .cfg_autostop(cfg_flags[FLG_AUTOSTOP]),
    .periph_req(periph_req), .erq_set(erq_set), .erq_clr(erq_clr),
    .major_hit(major_hit), .start_minor(start_minor),
    .rd_phase(rd_phase), .wr_phase(wr_phase), .minor_end(minor_end),
    .busy(busy), .erq(req_enabled)
  );

  dmach_addr #(.AW(AW), .OW(OW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load_ok),
    .cfg_src_addr(cfg_src_addr), .cfg_src_off(cfg_src_off),
    .cfg_dst_addr(cfg_dst_addr), .cfg_dst_off(cfg_dst_off),
    .cfg_dst_last(cfg_dst_last), .byte_wr(wr_phase),
    .major_hit(major_hit), .src_addr(src_addr), .dst_addr(dst_addr)
  );

  dmach_iter #(.CW(CW)) u_iter (
    .clk(clk), .rst_n(rst_n), .load(load_ok), .cfg_biter(cfg_biter),
    .cfg_done_ie(cfg_flags[FLG_DONE_IE]), .cfg_half_ie(cfg_flags[FLG_HALF_IE]),
    .minor_end(minor_end), .irq_clr(irq_clr), .citer(citer_out),
    .major_hit(major_hit), .irq_done(irq_done), .irq_half(irq_half)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata <= '0;
    else if (rd_phase) rdata <= prd_data;
  end

  assign prd_en       = rd_phase;
  assign prd_addr     = src_addr;
  assign mwr_en       = wr_phase;
  assign mwr_addr     = dst_addr;
  assign mwr_data     = rdata;
  assign dst_addr_out = dst_addr;

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mwr_en |-> $past(prd_en)); // R1
  AST_RD_LEADS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    prd_en |=> mwr_en && mwr_data == $past(prd_data)); // R1
  AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start_minor |=> !prd_en && !mwr_en); // R8
endmodule

// File: tb/tb_dma_rx_channel.sv
module tb_dma_rx_channel;
  localparam int AW = 16, OW = 8, CW = 8, NBW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 0;
  logic [AW-1:0] cfg_src_addr = '0, cfg_dst_addr = '0, cfg_dst_last = '0;
  logic [OW-1:0] cfg_src_off = '0, cfg_dst_off = '0;
  logic [CW-1:0] cfg_biter = 8'd1;
  logic [NBW-1:0] cfg_nbytes = 4'd1;
  logic [2:0] cfg_flags = '0;
  logic erq_set = 0, erq_clr = 0, periph_req = 0;
  logic [1:0] irq_clr = '0;
  logic prd_en, mwr_en, req_enabled, busy, irq_done, irq_half;
  logic [AW-1:0] prd_addr, mwr_addr, dst_addr_out;
  logic [7:0] prd_data, mwr_data, base_ch = 8'h00;
  logic [CW-1:0] citer_out;

  logic [7:0] mem [0:4095];
  int wcnt = 0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  assign prd_data = base_ch ^ prd_addr[7:0];

  always @(posedge clk) if (mwr_en) begin
    mem[mwr_addr[11:0]] <= mwr_data;
    wcnt <= wcnt + 1;
  end

  dma_rx_channel #(.AW(AW), .OW(OW), .CW(CW), .NBW(NBW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_src_addr(cfg_src_addr), .cfg_src_off(cfg_src_off),
    .cfg_dst_addr(cfg_dst_addr), .cfg_dst_off(cfg_dst_off),
    .cfg_dst_last(cfg_dst_last), .cfg_biter(cfg_biter),
    .cfg_nbytes(cfg_nbytes), .cfg_flags(cfg_flags),
    .erq_set(erq_set), .erq_clr(erq_clr), .irq_clr(irq_clr),
    .periph_req(periph_req), .prd_en(prd_en), .prd_addr(prd_addr),
    .prd_data(prd_data), .mwr_en(mwr_en), .mwr_addr(mwr_addr),
    .mwr_data(mwr_data), .req_enabled(req_enabled), .busy(busy),
    .citer_out(citer_out), .dst_addr_out(dst_addr_out),
    .irq_done(irq_done), .irq_half(irq_half)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic load_desc(input logic [15:0] sa, input logic [7:0] so,
                           input logic [15:0] da, input logic [7:0] dof,
                           input logic [15:0] dl, input logic [7:0] bi,
                           input logic [3:0] nb, input logic [2:0] fl);
    cfg_src_addr = sa; cfg_src_off = so; cfg_dst_addr = da; cfg_dst_off = dof;
    cfg_dst_last = dl; cfg_biter = bi; cfg_nbytes = nb; cfg_flags = fl;
    cfg_load = 1; @(negedge clk); cfg_load = 0;
  endtask

  task automatic pulse_set(); erq_set = 1; @(negedge clk); erq_set = 0; endtask

  task automatic wait_idle();
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
  endtask

  // raise the request, hold it past the loop, then release
  task automatic send(input logic [7:0] b, input int hold);
    base_ch = b; periph_req = 1;
    @(negedge clk);
    wait_idle();
    repeat (hold) @(negedge clk);
    periph_req = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    summary();
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    // reset state
    check(req_enabled == 0 && busy == 0, "R8 reset enable", req_enabled, 0);
    check(irq_done == 0 && irq_half == 0, "R7 reset irq", {irq_done, irq_half}, 0);
    check(citer_out == 1, "R4 reset count", citer_out, 1);
    rst_n = 1; @(negedge clk);

    // circular buffer of 4, fixed source
    load_desc(16'h0010, 8'd0, 16'h0100, 8'd1, -16'sd4, 8'd4, 4'd1, 3'b011);
    pulse_set();
    repeat (20) @(negedge clk);
    check(wcnt == 0, "R8 idle writes", wcnt, 0);
    check(citer_out == 4, "R8 idle count", citer_out, 4);
    for (int i = 0; i < 4; i++) begin
      w0 = wcnt;
      send(8'h30 + 8'(i), 5);
      check(wcnt == w0 + 1, "R9 single service", wcnt - w0, 1);
      check(mem[12'h100 + 12'(i)] == ((8'h30 + 8'(i)) ^ 8'h10), "R2 fixed source data",
            mem[12'h100 + 12'(i)], (8'h30 + i) ^ 8'h10);
      check(citer_out == ((i == 3) ? 4 : 3 - i), "R4 count", citer_out, (i == 3) ? 4 : 3 - i);
      if (i == 1) check(irq_half == 1 && irq_done == 0, "R7 half irq", {irq_done, irq_half}, 1);
    end
    check(irq_done == 1, "R7 done irq", irq_done, 1);
    check(dst_addr_out == 16'h0100, "R5 wrap to start", dst_addr_out, 16'h0100);
    check(req_enabled == 1, "R6 stays enabled without auto-stop", req_enabled, 1);
    send(8'h40, 1);
    check(mem[12'h100] == 8'h50, "R5 circular overwrite", mem[12'h100], 8'h50);
    irq_clr = 2'b01; @(negedge clk); irq_clr = 2'b00;
    check(irq_done == 0 && irq_half == 1, "R7 w1c done only", {irq_done, irq_half}, 1);
    irq_clr = 2'b10; @(negedge clk); irq_clr = 2'b00;
    check(irq_half == 0, "R7 w1c half", irq_half, 0);

    // two bytes per request, stepping source, auto-stop
    load_desc(16'h0020, 8'd1, 16'h0200, 8'd1, 16'd0, 8'd2, 4'd2, 3'b100);
    pulse_set();
    w0 = wcnt;
    send(8'h00, 2);
    send(8'h00, 2);
    check(wcnt == w0 + 4, "R1 bytes per request", wcnt - w0, 4);
    for (int j = 0; j < 4; j++)
      check(mem[12'h200 + 12'(j)] == 8'h20 + 8'(j), "R2 source step",
            mem[12'h200 + 12'(j)], 8'h20 + j);
    check(req_enabled == 0, "R6 auto-stop", req_enabled, 0);
    check(citer_out == 2 && irq_done == 0, "R7 done irq masked", {irq_done, citer_out}, 2);
    check(dst_addr_out == 16'h0204, "R5 zero adjustment", dst_addr_out, 16'h0204);
    w0 = wcnt;
    send(8'h00, 1);
    check(wcnt == w0, "R6 stopped channel ignores request", wcnt - w0, 0);

    // descending destination with positive end adjustment
    load_desc(16'h0030, 8'd0, 16'h0300, 8'hFF, 16'd3, 8'd3, 4'd1, 3'b001);
    pulse_set();
    for (int i = 0; i < 3; i++) send(8'h70 + 8'(i), 1);
    for (int i = 0; i < 3; i++)
      check(mem[12'h300 - 12'(i)] == ((8'h70 + 8'(i)) ^ 8'h30), "R3 negative step",
            mem[12'h300 - 12'(i)], (8'h70 + i) ^ 8'h30);
    check(dst_addr_out == 16'h0300, "R5 adjustment after step", dst_addr_out, 16'h0300);
    check(irq_done == 1, "R7 done after 3", irq_done, 1);

    // enable cleared mid-loop
    load_desc(16'h0040, 8'd0, 16'h0400, 8'd1, 16'd0, 8'd5, 4'd4, 3'b000);
    pulse_set();
    w0 = wcnt; base_ch = 8'h11; periph_req = 1;
    @(negedge clk);
    erq_clr = 1; @(negedge clk); erq_clr = 0;
    check(busy == 1 && req_enabled == 1, "R10 enable held during loop", req_enabled, 1);
    wait_idle();
    check(wcnt == w0 + 4, "R10 loop completes", wcnt - w0, 4);
    check(req_enabled == 0, "R10 enable drops at end", req_enabled, 0);
    periph_req = 0; repeat (2) @(negedge clk);
    w0 = wcnt;
    send(8'h22, 1);
    check(wcnt == w0 && citer_out == 4, "R10 disabled request ignored", wcnt - w0, 0);

    // descriptor load while busy
    pulse_set();
    w0 = wcnt; base_ch = 8'h33; periph_req = 1;
    @(negedge clk);
    cfg_dst_addr = 16'h0500; cfg_biter = 8'd7; cfg_load = 1;
    @(negedge clk); cfg_load = 0;
    wait_idle();
    periph_req = 0; repeat (2) @(negedge clk);
    check(wcnt == w0 + 4, "R11 loop unaffected", wcnt - w0, 4);
    check(mem[12'h407] == (8'h33 ^ 8'h40), "R11 old destination", mem[12'h407], 8'h33 ^ 8'h40);
    check(dst_addr_out == 16'h0408, "R11 address continues", dst_addr_out, 16'h0408);
    check(citer_out == 3, "R11 count not reloaded", citer_out, 3);

    summary();
  end
endmodule